// File: doc/BRIEF.md
# Packet Number Queue Manager

This block keeps the packet numbers that a network controller's transmit and receive paths hand between the host and the MAC. It holds three ordered queues. The pending queue feeds the MAC. The completion queue records each finished transmission together with a failure bit. The receive queue holds packets in the order they arrived. Only packet numbers are stored. Packet data stays in a separate buffer, so reordering, moving and discarding never copy any data.

The host issues one command per cycle on `cmd_op`/`cmd_pn`. With these commands it can queue a packet for transmission and release the head of the receive queue. It can also drop any entry by value, move a received packet into the pending queue, rotate the receive queue to change the order in which it processes packets, and discard or requeue a finished or failed transmission. A command that cannot be carried out changes nothing and pulses `cmd_err` in the same cycle. The MAC side drives three inputs: `rx_in_valid` pushes an arriving packet, `tx_take` claims the head of the pending queue, and `tx_finish` reports the outcome.

The transmit engine is a two-state machine. In `TXS_IDLE`, a take with a non-empty pending queue pops the head, latches its number and moves to `TXS_SEND` (transition *take*). In `TXS_SEND`, a finish pushes `{fail, pn}` into the completion queue and returns to `TXS_IDLE` (transition *finish*). Any other input leaves the state unchanged. Four level status bits are each ANDed with a mask bit and ORed into `irq`. In chain mode, the completion bit stays quiet until the whole chain has been sent.

Top module: `pnq_mgr`

## Requirements
- R1: After reset all three queues are empty, `tx_busy` is 0, and `irq_stat` is 4'b0100 (only the transmit-idle bit set).
- R2: Op 1 (`ENQ_TX`) appends `cmd_pn` to the pending queue, and the MAC receives packets in the order they were queued.
- R3: `tx_take` in `TXS_IDLE` with a non-empty pending queue pops the head into `tx_pn` and sets `tx_busy` on the next cycle. A take with an empty queue, or a take while busy, is ignored. `tx_finish` while busy appends `{~tx_ok, tx_pn}` to the completion queue (bit PNW is the failure bit) and clears `tx_busy`.
- R4: `rx_in_valid` appends `rx_in_pn` to the receive queue, `rx_head` shows the oldest entry, and op 2 (`RX_RELEASE`) removes that head.
- R5: Op 4 (`RX_DROP`) removes the first receive entry equal to `cmd_pn` from any position and keeps the order of the others. If no entry matches, `cmd_err` is raised and nothing changes.
- R6: Op 3 (`RX_TO_TX`) pops the receive head and appends it to the pending queue. If the pending queue is full, the command is rejected with `cmd_err` and the receive queue keeps its head.
- R7: Op 5 (`RX_ROTATE`) moves the receive head to the tail. If `rx_in_valid` is high in the same cycle, the rotate is rejected with `cmd_err`.
- R8: Op 6 (`DONE_POP`) discards the completion head. Op 7 (`DONE_REQUEUE`) pops it and appends its packet number to the pending queue. Op 10 (`DONE_DROP`) removes the first completion entry whose packet number equals `cmd_pn`.
- R9: Op 8 (`TX_DROP`) removes the first pending entry equal to `cmd_pn`. If a MAC take is accepted in the same cycle, or no entry matches, the command is rejected with `cmd_err`.
- R10: A push into a full queue is ignored and sets the sticky overflow bit `irq_stat[3]`. Op 9 (`CLR_OVF`) clears that bit.
- R11: A pop, move or requeue from an empty queue, or an op code outside 0..10, raises `cmd_err` and leaves every queue unchanged.
- R12: The `irq_stat` bits are: bit 0 receive queue non-empty, bit 1 transmit completion, bit 2 pending queue empty and engine idle, bit 3 overflow. `irq` is the OR of `irq_stat & irq_mask`.
- R13: With `chain_mode` high, `irq_stat[1]` is set only when the completion queue is non-empty and either the pending queue is empty with the engine idle, or the completion head carries the failure bit. With `chain_mode` low, the bit is set whenever the completion queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 4 | Host command code |
| cmd_pn | input | PNW | Packet number operand |
| cmd_err | output | 1 | Command rejected (same cycle) |
| rx_in_valid | input | 1 | Arriving packet push |
| rx_in_pn | input | PNW | Arriving packet number |
| rx_head | output | PNW | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_take | input | 1 | MAC claims the next pending packet |
| tx_finish | input | 1 | MAC reports end of transmission |
| tx_ok | input | 1 | Transmission succeeded |
| tx_busy | output | 1 | Engine in `TXS_SEND` |
| tx_pn | output | PNW | Packet number being sent |
| tx_empty | output | 1 | Pending queue empty |
| tx_full | output | 1 | Pending queue full |
| done_head | output | PNW+1 | Completion head `{fail, pn}` |
| done_empty | output | 1 | Completion queue empty |
| done_full | output | 1 | Completion queue full |
| chain_mode | input | 1 | One completion interrupt per chain |
| irq_mask | input | 4 | Per-source enable |
| irq_stat | output | 4 | Level status bits |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with PNW=5 and DEPTH=4. This makes the full-queue cases reachable in four pushes: an ignored push with overflow, and a move rejected by a full pending queue. It also lets drop-by-value hit the head, the middle and a missing value. A four-entry completion queue holds a whole chain plus a failed entry, so the chain-mode completion bit is seen both held back and released.

// File: rtl/pnq_pkg.sv
package pnq_pkg;
    typedef enum logic [3:0] {
        OP_NOP          = 4'd0,
        OP_ENQ_TX       = 4'd1,
        OP_RX_RELEASE   = 4'd2,
        OP_RX_TO_TX     = 4'd3,
        OP_RX_DROP      = 4'd4,
        OP_RX_ROTATE    = 4'd5,
        OP_DONE_POP     = 4'd6,
        OP_DONE_REQUEUE = 4'd7,
        OP_TX_DROP      = 4'd8,
        OP_CLR_OVF      = 4'd9,
        OP_DONE_DROP    = 4'd10
    } pnq_op_e;

    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_SEND = 1'b1
    } txs_e;

    localparam int IRQ_RX  = 0;
    localparam int IRQ_TXC = 1;
    localparam int IRQ_TXE = 2;
    localparam int IRQ_OVF = 3;
    localparam int IRQ_N   = 4;
endpackage

// File: rtl/pnq_queue.sv
// Ordered queue with one push, one delete at any index and a value search per cycle.
module pnq_queue #(
    parameter int W     = 5,
    parameter int KW    = 5,
    parameter int DEPTH = 24,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          del,
    input  logic [IW-1:0] del_idx,
    input  logic [KW-1:0] find_val,
    output logic          find_hit,
    output logic [IW-1:0] find_idx,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  nxt [DEPTH];
    logic [CW-1:0] cnt, ncnt;
    logic          push_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push && (!full || del);
    assign ovf     = push && full && !del;
    assign head    = mem[0];

    always_comb begin
        nxt  = mem;
        ncnt = cnt;
        if (del && !empty) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= del_idx) nxt[i] = mem[i+1];
            end
            ncnt = cnt - CW'(1);
        end
        if (push_ok) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == ncnt) nxt[i] = push_data;
            end
            ncnt = ncnt + CW'(1);
        end
    end

    // lowest matching position wins
    always_comb begin
        find_hit = 1'b0;
        find_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CW'(i) < cnt && mem[i][KW-1:0] == find_val) begin
                find_hit = 1'b1;
                find_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            cnt <= ncnt;
            for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/pnq_txeng.sv
// Transmit engine: claims the pending head, records the outcome.
module pnq_txeng
    import pnq_pkg::*;
#(
    parameter int PNW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_take,
    input  logic           tx_finish,
    input  logic           tx_ok,
    input  logic           q_empty,
    input  logic [PNW-1:0] q_head,
    output logic           take_pop,
    output logic           busy,
    output logic [PNW-1:0] pn,
    output logic           done_push,
    output logic [PNW:0]   done_data
);
    txs_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TXS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        take_pop  = 1'b0;
        done_push = 1'b0;
        unique case (state)
            TXS_IDLE: begin
                if (tx_take && !q_empty) begin
                    take_pop  = 1'b1;
                    state_nxt = TXS_SEND;
                end
            end
            TXS_SEND: begin
                if (tx_finish) begin
                    done_push = 1'b1;
                    state_nxt = TXS_IDLE;
                end
            end
            default: state_nxt = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        pn <= '0;
        else if (take_pop) pn <= q_head;
    end

    assign busy      = (state == TXS_SEND);
    assign done_data = {!tx_ok, pn};
endmodule

// File: rtl/pnq_irq.sv
// Status bits, chain gating and masked interrupt merge.
module pnq_irq
    import pnq_pkg::*;
(
    input  logic             rx_empty,
    input  logic             tx_empty,
    input  logic             busy,
    input  logic             done_empty,
    input  logic             done_fail,
    input  logic             chain_mode,
    input  logic             ovf_flag,
    input  logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] stat,
    output logic             irq
);
    logic idle_drained;

    assign idle_drained  = tx_empty && !busy;
    assign stat[IRQ_RX]  = !rx_empty;
    assign stat[IRQ_TXC] = !done_empty && (!chain_mode || idle_drained || done_fail);
    assign stat[IRQ_TXE] = idle_drained;
    assign stat[IRQ_OVF] = ovf_flag;
    assign irq           = |(stat & mask);
endmodule

// File: rtl/pnq_mgr.sv
module pnq_mgr
    import pnq_pkg::*;
#(
    parameter int PNW   = 5,
    parameter int DEPTH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [PNW-1:0] cmd_pn,
    output logic           cmd_err,
    input  logic           rx_in_valid,
    input  logic [PNW-1:0] rx_in_pn,
    output logic [PNW-1:0] rx_head,
    output logic           rx_empty,
    output logic           rx_full,
    input  logic           tx_take,
    input  logic           tx_finish,
    input  logic           tx_ok,
    output logic           tx_busy,
    output logic [PNW-1:0] tx_pn,
    output logic           tx_empty,
    output logic           tx_full,
    output logic [PNW:0]   done_head,
    output logic           done_empty,
    output logic           done_full,
    input  logic           chain_mode,
    input  logic [3:0]     irq_mask,
    output logic [3:0]     irq_stat,
    output logic           irq
);
    localparam int IW = $clog2(DEPTH);

    pnq_op_e        op;
    logic           take_pop, done_push;
    logic [PNW:0]   done_data;
    logic [PNW-1:0] tx_head;
    logic           tx_hit, rx_hit, done_hit;
    logic [IW-1:0]  tx_fidx, rx_fidx, done_fidx;
    logic           tx_ovf, rx_ovf, done_ovf, ovf_flag;

    logic           h_tx_push, h_tx_del, h_rx_del, h_rx_rot, h_done_del, h_clr;
    logic [PNW-1:0] h_tx_data;
    logic [IW-1:0]  h_tx_idx, h_rx_idx, h_done_idx;
    logic           tx_room;

    assign op      = cmd_valid ? pnq_op_e'(cmd_op) : OP_NOP;
    assign tx_room = !tx_full || take_pop;

    // host command decode
    always_comb begin
        h_tx_push  = 1'b0; h_tx_data = cmd_pn; h_tx_del  = 1'b0; h_tx_idx  = tx_fidx;
        h_rx_del   = 1'b0; h_rx_idx  = '0;     h_rx_rot  = 1'b0;
        h_done_del = 1'b0; h_done_idx = '0;    h_clr     = 1'b0;
        cmd_err    = 1'b0;
        unique case (op)
            OP_NOP: ;
            OP_ENQ_TX: h_tx_push = 1'b1;
            OP_RX_RELEASE: begin
                if (rx_empty) cmd_err  = 1'b1;
                else          h_rx_del = 1'b1;
            end
            OP_RX_TO_TX: begin
                if (rx_empty || !tx_room) cmd_err = 1'b1;
                else begin
                    h_rx_del  = 1'b1;
                    h_tx_push = 1'b1;
                    h_tx_data = rx_head;
                end
            end
            OP_RX_DROP: begin
                if (!rx_hit) cmd_err = 1'b1;
                else begin
                    h_rx_del = 1'b1;
                    h_rx_idx = rx_fidx;
                end
            end
            OP_RX_ROTATE: begin
                if (rx_empty || rx_in_valid) cmd_err = 1'b1;
                else begin
                    h_rx_del = 1'b1;
                    h_rx_rot = 1'b1;
                end
            end
            OP_DONE_POP: begin
                if (done_empty) cmd_err    = 1'b1;
                else            h_done_del = 1'b1;
            end
            OP_DONE_REQUEUE: begin
                if (done_empty || !tx_room) cmd_err = 1'b1;
                else begin
                    h_done_del = 1'b1;
                    h_tx_push  = 1'b1;
                    h_tx_data  = done_head[PNW-1:0];
                end
            end
            OP_TX_DROP: begin
                if (take_pop || !tx_hit) cmd_err  = 1'b1;
                else                     h_tx_del = 1'b1;
            end
            OP_CLR_OVF: h_clr = 1'b1;
            OP_DONE_DROP: begin
                if (!done_hit) cmd_err = 1'b1;
                else begin
                    h_done_del = 1'b1;
                    h_done_idx = done_fidx;
                end
            end
            default: cmd_err = 1'b1;
        endcase
    end

    pnq_queue #(.W(PNW), .KW(PNW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(h_tx_push), .push_data(h_tx_data),
        .del(take_pop || h_tx_del), .del_idx(take_pop ? '0 : h_tx_idx),
        .find_val(cmd_pn), .find_hit(tx_hit), .find_idx(tx_fidx),
        .head(tx_head), .empty(tx_empty), .full(tx_full), .ovf(tx_ovf)
    );

    pnq_queue #(.W(PNW), .KW(PNW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_in_valid || h_rx_rot), .push_data(rx_in_valid ? rx_in_pn : rx_head),
        .del(h_rx_del), .del_idx(h_rx_idx),
        .find_val(cmd_pn), .find_hit(rx_hit), .find_idx(rx_fidx),
        .head(rx_head), .empty(rx_empty), .full(rx_full), .ovf(rx_ovf)
    );

    pnq_queue #(.W(PNW + 1), .KW(PNW), .DEPTH(DEPTH)) u_doneq (
        .clk(clk), .rst_n(rst_n),
        .push(done_push), .push_data(done_data),
        .del(h_done_del), .del_idx(h_done_idx),
        .find_val(cmd_pn), .find_hit(done_hit), .find_idx(done_fidx),
        .head(done_head), .empty(done_empty), .full(done_full), .ovf(done_ovf)
    );

    pnq_txeng #(.PNW(PNW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .tx_take(tx_take), .tx_finish(tx_finish), .tx_ok(tx_ok),
        .q_empty(tx_empty), .q_head(tx_head),
        .take_pop(take_pop), .busy(tx_busy), .pn(tx_pn),
        .done_push(done_push), .done_data(done_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                            ovf_flag <= 1'b0;
        else if (tx_ovf || rx_ovf || done_ovf) ovf_flag <= 1'b1;
        else if (h_clr)                        ovf_flag <= 1'b0;
    end

    pnq_irq u_irq (
        .rx_empty(rx_empty), .tx_empty(tx_empty), .busy(tx_busy),
        .done_empty(done_empty), .done_fail(done_head[PNW]),
        .chain_mode(chain_mode), .ovf_flag(ovf_flag),
        .mask(irq_mask), .stat(irq_stat), .irq(irq)
    );
endmodule

// File: rtl/pnq_mgr_chk.sv
module pnq_mgr_chk #(
    parameter int PNW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [3:0]     cmd_op,
    input logic           rx_in_valid,
    input logic           rx_empty,
    input logic           rx_full,
    input logic           tx_take,
    input logic           tx_finish,
    input logic           tx_busy,
    input logic [PNW-1:0] tx_pn,
    input logic           tx_empty,
    input logic [PNW:0]   done_head,
    input logic           done_empty,
    input logic           done_full,
    input logic           chain_mode,
    input logic [3:0]     irq_stat
);
    AST_TAKE_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_empty && tx_take) |=> !tx_busy); // R3
    AST_BUSY_HOLDS_PN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_finish) |=> (tx_busy && $stable(tx_pn))); // R3
    AST_FINISH_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_finish && !done_full) |=> (!done_empty && !tx_busy)); // R3
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd2 && rx_empty && !rx_in_valid) |=> rx_empty); // R11
    AST_FULL_PUSH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_in_valid && !(cmd_valid && cmd_op inside {4'd2, 4'd3, 4'd4}))
        |=> (irq_stat[3] && rx_full)); // R10
    AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && !tx_empty && !done_head[PNW]) |-> !irq_stat[1]); // R13
endmodule

bind pnq_mgr pnq_mgr_chk #(.PNW(PNW)) u_chk (.*);

// File: tb/pnq_mgr_test.sv
`timescale 1ns/1ps
module pnq_mgr_test;
    localparam int PNW = 5;
    localparam int DEPTH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [3:0]     cmd_op = '0;
    logic [PNW-1:0] cmd_pn = '0;
    logic           cmd_err;
    logic           rx_in_valid = 1'b0;
    logic [PNW-1:0] rx_in_pn = '0;
    logic [PNW-1:0] rx_head;
    logic           rx_empty, rx_full;
    logic           tx_take = 1'b0, tx_finish = 1'b0, tx_ok = 1'b0;
    logic           tx_busy;
    logic [PNW-1:0] tx_pn;
    logic           tx_empty, tx_full;
    logic [PNW:0]   done_head;
    logic           done_empty, done_full;
    logic           chain_mode = 1'b0;
    logic [3:0]     irq_mask = '0;
    logic [3:0]     irq_stat;
    logic           irq;

    int  n_chk = 0;
    int  n_err = 0;
    logic last_err;

    always #2.5 clk = ~clk;

    pnq_mgr #(.PNW(PNW), .DEPTH(DEPTH)) uut (.*);

    // {op, pn, rx_v, rx_pn, exp_err, exp_empty, exp_head}
    localparam int VN = 11;
    localparam logic [21:0] VEC [VN] = '{
        {4'd0, 5'd0,  1'b1, 5'd3, 1'b0, 1'b0, 5'd3},
        {4'd0, 5'd0,  1'b1, 5'd7, 1'b0, 1'b0, 5'd3},
        {4'd0, 5'd0,  1'b1, 5'd9, 1'b0, 1'b0, 5'd3},
        {4'd4, 5'd7,  1'b0, 5'd0, 1'b0, 1'b0, 5'd3},
        {4'd4, 5'd12, 1'b0, 5'd0, 1'b1, 1'b0, 5'd3},
        {4'd5, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, 5'd9},
        {4'd5, 5'd0,  1'b1, 5'd5, 1'b1, 1'b0, 5'd9},
        {4'd2, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, 5'd3},
        {4'd2, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, 5'd5},
        {4'd2, 5'd0,  1'b0, 5'd0, 1'b0, 1'b1, 5'd0},
        {4'd2, 5'd0,  1'b0, 5'd0, 1'b1, 1'b1, 5'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] op, input logic [4:0] pn, input logic rv,
                       input logic [4:0] rpn, input logic tk, input logic fn, input logic ok);
        @(negedge clk);
        cmd_valid = (op != 4'd0); cmd_op = op; cmd_pn = pn;
        rx_in_valid = rv; rx_in_pn = rpn;
        tx_take = tk; tx_finish = fn; tx_ok = ok;
        #1 last_err = cmd_err;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; cmd_op = '0; cmd_pn = '0; rx_in_valid = 1'b0;
        tx_take = 1'b0; tx_finish = 1'b0; tx_ok = 1'b0;
    endtask

    task automatic host(input logic [3:0] op, input logic [4:0] pn);
        cyc(op, pn, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    endtask
    task automatic take();
        cyc(4'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    endtask
    task automatic fin(input logic ok);
        cyc(4'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, ok);
    endtask
    task automatic drain_done();
        for (int k = 0; k < 8; k++) if (!done_empty) host(4'd6, 5'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 done_empty", done_empty, 1);
        chk("R1 busy", tx_busy, 0);
        chk("R1 irq_stat", irq_stat, 4'b0100);
        chk("R1 irq", irq, 0);

        // receive-side table: R4 R5 R7 R11
        for (int v = 0; v < VN; v++) begin
            cyc(VEC[v][21:18], VEC[v][17:13], VEC[v][12], VEC[v][11:7], 1'b0, 1'b0, 1'b0);
            chk($sformatf("R4/R5/R7/R11 vec%0d err", v), last_err, VEC[v][6]);
            chk($sformatf("R4 vec%0d empty", v), rx_empty, VEC[v][5]);
            if (!VEC[v][5]) chk($sformatf("R4 vec%0d head", v), rx_head, VEC[v][4:0]);
        end

        // R3 take with empty queue ignored
        take();
        chk("R3 take empty", tx_busy, 0);
        // R2 order
        host(4'd1, 5'd4); host(4'd1, 5'd6);
        chk("R2 tx nonempty", tx_empty, 0);
        take();
        chk("R3 busy", tx_busy, 1);
        chk("R2 first pn", tx_pn, 4);
        take();
        chk("R3 take while busy", tx_pn, 4);
        fin(1'b1);
        chk("R3 idle after finish", tx_busy, 0);
        chk("R3 done head ok", done_head, 6'h04);
        take();
        chk("R2 second pn", tx_pn, 6);
        fin(1'b0);
        chk("R3 done head kept", done_head, 6'h04);
        chk("R2 tx drained", tx_empty, 1);

        // R12 status and mask
        irq_mask = 4'b0010; #1;
        chk("R12 stat", irq_stat, 4'b0110);
        chk("R12 irq masked in", irq, 1);
        irq_mask = 4'b0001; #1;
        chk("R12 irq masked out", irq, 0);
        irq_mask = 4'b0000;

        // R8 completion handling
        host(4'd6, 5'd0);
        chk("R8 pop shows fail entry", done_head, 6'h26);
        host(4'd7, 5'd0);
        chk("R8 requeue err", last_err, 0);
        chk("R8 done empty", done_empty, 1);
        chk("R8 tx refilled", tx_empty, 0);
        take();
        chk("R8 requeued pn", tx_pn, 6);
        fin(1'b1);

        // R13 chain mode
        chain_mode = 1'b1; #1;
        chk("R13 idle chain done", irq_stat[1], 1);
        host(4'd1, 5'd2); host(4'd1, 5'd3);
        chk("R13 pending held", irq_stat[1], 0);
        take(); fin(1'b1);
        chk("R13 mid chain", irq_stat[1], 0);
        take();
        chk("R13 last in flight", irq_stat[1], 0);
        fin(1'b1);
        chk("R13 chain complete", irq_stat[1], 1);
        drain_done();
        host(4'd1, 5'd7); host(4'd1, 5'd8);
        take(); fin(1'b0);
        chk("R13 fail breaks chain", irq_stat[1], 1);
        take(); fin(1'b1);
        drain_done();
        chain_mode = 1'b0;

        // R9 pending drop
        host(4'd1, 5'd1); host(4'd1, 5'd2); host(4'd1, 5'd3);
        host(4'd8, 5'd2);
        chk("R9 drop err", last_err, 0);
        take(); chk("R9 head after drop", tx_pn, 1); fin(1'b1);
        take(); chk("R9 middle removed", tx_pn, 3); fin(1'b1);
        host(4'd1, 5'd5); host(4'd1, 5'd8);
        cyc(4'd8, 5'd8, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
        chk("R9 drop vs take err", last_err, 1);
        chk("R9 take won", tx_pn, 5);
        fin(1'b1);
        take(); chk("R9 entry kept", tx_pn, 8); fin(1'b1);
        drain_done();

        // R10 overflow, R6 move rejected on full
        host(4'd1, 5'd10); host(4'd1, 5'd11); host(4'd1, 5'd12); host(4'd1, 5'd13);
        chk("R10 full", tx_full, 1);
        host(4'd1, 5'd14);
        chk("R10 ovf set", irq_stat[3], 1);
        host(4'd8, 5'd14);
        chk("R10 push ignored", last_err, 1);
        cyc(4'd0, 5'd0, 1'b1, 5'd11, 1'b0, 1'b0, 1'b0);
        host(4'd3, 5'd0);
        chk("R6 full reject", last_err, 1);
        chk("R6 rx kept", rx_empty, 0);
        host(4'd9, 5'd0);
        chk("R10 ovf cleared", irq_stat[3], 0);
        for (int p = 10; p < 14; p++) host(4'd8, 5'(p));
        chk("R9 all dropped", tx_empty, 1);
        host(4'd3, 5'd0);
        chk("R6 move err", last_err, 0);
        chk("R6 rx emptied", rx_empty, 1);
        take();
        chk("R6 moved pn", tx_pn, 11);
        fin(1'b1);
        drain_done();

        // R11 empty and illegal
        host(4'd6, 5'd0);  chk("R11 done pop empty", last_err, 1);
        host(4'd8, 5'd3);  chk("R11 tx drop empty", last_err, 1);
        host(4'd3, 5'd0);  chk("R11 move empty", last_err, 1);
        host(4'd15, 5'd0); chk("R11 illegal op", last_err, 1);
        chk("R11 tx unchanged", tx_empty, 1);

        // R8 drop by value in completion queue
        host(4'd1, 5'd20); host(4'd1, 5'd21);
        take(); fin(1'b1); take(); fin(1'b1);
        host(4'd10, 5'd30);
        chk("R8 done drop miss", last_err, 1);
        host(4'd10, 5'd21);
        chk("R8 done drop err", last_err, 0);
        chk("R8 done head", done_head, 6'h14);
        host(4'd6, 5'd0);
        chk("R8 done emptied", done_empty, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule